// File: doc/BRIEF.md
# Banked Shared-Memory Crossbar Arbiter

This block connects a set of bus masters to a shared on-chip memory that is split into independent banks. Each master has its own path to every bank, so two masters slow each other down only when they address the same bank in the same cycle. Every bank has its own round-robin arbiter. The arbiter admits one access per cycle. Requests to other banks proceed in parallel and are not affected.

A single mode input sets how word addresses are spread across banks, and it may be changed at run time. With interleaved placement, consecutive words fall in consecutive banks. With blocked placement, each bank holds one contiguous slice of the address space. Each master port uses a valid/ready handshake. A request is accepted in the same cycle its ready is high. A read returns its data on that master's response outputs exactly one cycle after acceptance. Each bank is a single-port synchronous memory held in an array.

Each bank keeps a small state machine that records what it did in the previous cycle:
- `BK_IDLE` means no access was granted.
- `BK_READ` means a read was granted, so its data and owner are now presented.
- `BK_WRITE` means a write was granted.

On every clock edge the next state is chosen the same way, whatever the current state:
- A granted read moves the bank to `BK_READ`.
- A granted write moves it to `BK_WRITE`.
- A cycle with no grant moves it to `BK_IDLE`.

Top module: `smem_xbar`

## Requirements
- R1: While reset is held low and just after, with no requests, no `m_ready` and no `m_rvalid` bit is high.
- R2: With `map_blocked` = 0, the bank index is the word address modulo NUM_BANKS (its low log2(NUM_BANKS) bits), and the row is the remaining upper bits.
- R3: With `map_blocked` = 1, the bank index is the top log2(NUM_BANKS) address bits, and the row is the remaining lower bits.
- R4: A bank accepts at most one request per cycle. `m_ready` is high only for a master whose `m_valid` is high, in the cycle the request is taken.
- R5: A master that is the only requester of its target bank is accepted in that same cycle, whatever other masters do at other banks.
- R6: Among the masters requesting one bank, the winner is the first requester found by scanning master indices upward from the bank's pointer, wrapping from NUM_MASTERS-1 to 0.
- R7: A bank's pointer becomes (winner index + 1) mod NUM_MASTERS after a grant. It stays unchanged in cycles without a grant at that bank.
- R8: An accepted write stores its data in the addressed bank row and produces no response.
- R9: An accepted read raises `m_rvalid` of that master for exactly one cycle, on the next clock edge. It carries the row's content in `m_rdata`, and that content includes writes accepted in earlier cycles.
- R10: A master whose request is not accepted keeps `m_valid` high and its address, write flag and write data unchanged until it is accepted.
- R11: Placement depends only on the mode at the time of access. Data written in one mode is read back in the other mode at the address that decodes to the same bank and row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| map_blocked | input | 1 | Bank placement: 0 interleaved, 1 blocked |
| m_valid | input | NUM_MASTERS | Request valid, one bit per master |
| m_write | input | NUM_MASTERS | 1 write, 0 read, per master |
| m_addr | input | NUM_MASTERS*ADDR_W | Word address, master i at bits [i*ADDR_W +: ADDR_W] |
| m_wdata | input | NUM_MASTERS*DATA_W | Write data, master i at bits [i*DATA_W +: DATA_W] |
| m_ready | output | NUM_MASTERS | Request accepted this cycle |
| m_rvalid | output | NUM_MASTERS | Read data valid |
| m_rdata | output | NUM_MASTERS*DATA_W | Read data, master i at bits [i*DATA_W +: DATA_W] |

## Verification
Acceptance is combinational, so `m_ready` is due in the cycle the request is driven. The bench drives requests on the falling edge and samples `m_ready` two nanoseconds later, before the rising edge. Read data passes through one register, so `m_rvalid` and `m_rdata` are due after the following rising edge. The bench checks them at the next falling edge, against the memory image its own model held when the grant was predicted. Each grant is predicted from a per-bank pointer kept in the bench. Each batch is also timed in steps: one step when all banks differ, one step per master when all masters collide.

// File: rtl/smem_pkg.sv
package smem_pkg;

    // What a bank did on the previous clock edge
    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_READ  = 2'd1,
        BK_WRITE = 2'd2
    } bank_state_e;

endpackage

// File: rtl/smem_addr_map.sv
module smem_addr_map #(
    parameter int ADDR_W    = 8,
    parameter int BANK_BITS = 2
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        blocked,
    output logic [BANK_BITS-1:0]        bank,
    output logic [ADDR_W-BANK_BITS-1:0] row
);

    localparam int ROW_W = ADDR_W - BANK_BITS;

    // R2 / R3: the bank field is taken from the low or the high end of the address
    always_comb begin
        if (blocked) begin
            bank = addr[ADDR_W-1 -: BANK_BITS];
            row  = addr[ROW_W-1:0];
        end else begin
            bank = addr[BANK_BITS-1:0];
            row  = addr[ADDR_W-1:BANK_BITS];
        end
    end

endmodule

// File: rtl/smem_rr_arb.sv
module smem_rr_arb #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic          gnt_any,
    output logic [IW-1:0] gnt_idx
);

    logic [IW-1:0] ptr;
    logic [IW-1:0] ptr_nxt;

    // Scan upward from the pointer, wrapping, and take the first requester
    always_comb begin
        gnt     = '0;
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int off = 0; off < N; off++) begin
            int            cand;
            logic [IW-1:0] cand_i;
            cand = int'(ptr) + off;
            if (cand >= N) cand = cand - N;
            cand_i = IW'(cand);
            if (!gnt_any && req[cand_i]) begin
                gnt_any     = 1'b1;
                gnt[cand_i] = 1'b1;
                gnt_idx     = cand_i;
            end
        end
    end

    assign ptr_nxt = (gnt_idx == IW'(N-1)) ? '0 : gnt_idx + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= '0;
        else if (gnt_any) ptr <= ptr_nxt;
    end

    // R4
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R4
    gnt_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);

    // R6
    ptr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req[ptr] |-> gnt[ptr]);

    // R7
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_any |=> $stable(ptr));

endmodule

// File: rtl/smem_bank.sv
module smem_bank
    import smem_pkg::*;
#(
    parameter int NM = 4,
    parameter int DW = 32,
    parameter int RW = 6,
    parameter int IW = $clog2(NM)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NM-1:0]          req,
    input  logic [NM-1:0]          wr,
    input  logic [NM-1:0][RW-1:0]  row,
    input  logic [NM-1:0][DW-1:0]  wdata,
    output logic [NM-1:0]          gnt,
    output logic                   rsp_valid,
    output logic [IW-1:0]          rsp_idx,
    output logic [DW-1:0]          rsp_data
);

    localparam int DEPTH = 1 << RW;

    logic          gnt_any;
    logic [IW-1:0] gnt_idx;
    logic          sel_we;
    logic [RW-1:0] sel_row;
    logic [DW-1:0] sel_wd;

    bank_state_e   state_q, state_d;
    logic [IW-1:0] owner_q;
    logic [DW-1:0] rd_q;
    logic [DW-1:0] mem [DEPTH];

    smem_rr_arb #(.N(NM), .IW(IW)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .gnt     (gnt),
        .gnt_any (gnt_any),
        .gnt_idx (gnt_idx)
    );

    assign sel_we  = wr[gnt_idx];
    assign sel_row = row[gnt_idx];
    assign sel_wd  = wdata[gnt_idx];

    // Next state: decided by what is granted this cycle
    always_comb begin
        unique case ({gnt_any, sel_we})
            2'b10:   state_d = BK_READ;
            2'b11:   state_d = BK_WRITE;
            default: state_d = BK_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            if (gnt_any) owner_q <= gnt_idx;
        end
    end

    // Single-port array, one access per cycle
    always_ff @(posedge clk) begin
        if (gnt_any) begin
            if (sel_we) mem[sel_row] <= sel_wd;
            else        rd_q         <= mem[sel_row];
        end
    end

    // Outputs
    always_comb begin
        rsp_valid = 1'b0;
        unique case (state_q)
            BK_IDLE:  rsp_valid = 1'b0;
            BK_READ:  rsp_valid = 1'b1;
            BK_WRITE: rsp_valid = 1'b0;
            default:  rsp_valid = 1'b0;
        endcase
        rsp_idx  = owner_q;
        rsp_data = rd_q;
    end

    // R8
    write_norsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_any && sel_we) |=> !rsp_valid);

endmodule

// File: rtl/smem_xbar.sv
module smem_xbar #(
    parameter int NUM_MASTERS = 4,
    parameter int NUM_BANKS   = 4,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          map_blocked,
    input  logic [NUM_MASTERS-1:0]        m_valid,
    input  logic [NUM_MASTERS-1:0]        m_write,
    input  logic [NUM_MASTERS*ADDR_W-1:0] m_addr,
    input  logic [NUM_MASTERS*DATA_W-1:0] m_wdata,
    output logic [NUM_MASTERS-1:0]        m_ready,
    output logic [NUM_MASTERS-1:0]        m_rvalid,
    output logic [NUM_MASTERS*DATA_W-1:0] m_rdata
);

    localparam int BB = $clog2(NUM_BANKS);
    localparam int RW = ADDR_W - BB;
    localparam int IW = $clog2(NUM_MASTERS);

    logic [NUM_MASTERS-1:0][BB-1:0]        mst_bank;
    logic [NUM_MASTERS-1:0][RW-1:0]        mst_row;
    logic [NUM_MASTERS-1:0][DATA_W-1:0]    mst_wd;
    logic [NUM_BANKS-1:0][NUM_MASTERS-1:0] bk_req;
    logic [NUM_BANKS-1:0][NUM_MASTERS-1:0] bk_gnt;
    logic [NUM_MASTERS-1:0][NUM_BANKS-1:0] mst_gnt;
    logic [NUM_BANKS-1:0]                  bk_rv;
    logic [NUM_BANKS-1:0][IW-1:0]          bk_ridx;
    logic [NUM_BANKS-1:0][DATA_W-1:0]      bk_rdata;

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mst
        smem_addr_map #(.ADDR_W(ADDR_W), .BANK_BITS(BB)) u_map (
            .addr    (m_addr[m*ADDR_W +: ADDR_W]),
            .blocked (map_blocked),
            .bank    (mst_bank[m]),
            .row     (mst_row[m])
        );
        assign mst_wd[m] = m_wdata[m*DATA_W +: DATA_W];
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_req
            assign bk_req[b][m]  = m_valid[m] && (mst_bank[m] == BB'(b));
            assign mst_gnt[m][b] = bk_gnt[b][m];
        end

        smem_bank #(.NM(NUM_MASTERS), .DW(DATA_W), .RW(RW), .IW(IW)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (bk_req[b]),
            .wr        (m_write),
            .row       (mst_row),
            .wdata     (mst_wd),
            .gnt       (bk_gnt[b]),
            .rsp_valid (bk_rv[b]),
            .rsp_idx   (bk_ridx[b]),
            .rsp_data  (bk_rdata[b])
        );
    end

    // Ready and response steering back to each master
    always_comb begin
        m_ready  = '0;
        m_rvalid = '0;
        m_rdata  = '0;
        for (int m = 0; m < NUM_MASTERS; m++) begin
            m_ready[m] = |mst_gnt[m];
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bk_rv[b] && bk_ridx[b] == IW'(m)) begin
                    m_rvalid[m]                 = 1'b1;
                    m_rdata[m*DATA_W +: DATA_W] = bk_rdata[b];
                end
            end
        end
    end

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_chk
        // R4
        rdy_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            m_ready[m] |-> m_valid[m]);

        // R5
        one_bank_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(mst_gnt[m]));

        // R5
        sole_req_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (m_valid[m] && $countones(bk_req[mst_bank[m]]) == 1) |-> m_ready[m]);

        // R9
        rd_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (m_valid[m] && m_ready[m] && !m_write[m]) |=> m_rvalid[m]);

        // R9
        no_spur_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(m_valid[m] && m_ready[m] && !m_write[m]) |=> !m_rvalid[m]);

        // R10
        hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (m_valid[m] && !m_ready[m]) |=>
                (m_valid[m] && $stable(m_write[m]) &&
                 $stable(m_addr[m*ADDR_W +: ADDR_W]) &&
                 $stable(m_wdata[m*DATA_W +: DATA_W])));
    end

endmodule

// File: tb/smem_xbar_tb_top.sv
module smem_xbar_tb_top;

    localparam int NM   = 4;
    localparam int NB   = 4;
    localparam int DW   = 32;
    localparam int AW   = 8;
    localparam int ROWS = (1 << AW) / NB;
    localparam int WORDS = NB * ROWS;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n;
    logic              map_blocked;
    logic [NM-1:0]     m_valid, m_write, m_ready, m_rvalid;
    logic [NM*AW-1:0]  m_addr;
    logic [NM*DW-1:0]  m_wdata, m_rdata;

    smem_xbar #(.NUM_MASTERS(NM), .NUM_BANKS(NB), .DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .map_blocked (map_blocked),
        .m_valid     (m_valid),
        .m_write     (m_write),
        .m_addr      (m_addr),
        .m_wdata     (m_wdata),
        .m_ready     (m_ready),
        .m_rvalid    (m_rvalid),
        .m_rdata     (m_rdata)
    );

    int          n_tests = 0;
    int          n_fail  = 0;
    bit          finished = 1'b0;
    bit          blk;
    int          p_addr [NM];
    bit          p_we   [NM];
    logic [DW-1:0] p_wd [NM];
    bit          p_pend [NM];
    logic [DW-1:0] model [WORDS];
    int          exp_ptr [NB];

    // R2 / R3 placement rules
    function automatic int bank_of(int a);
        return blk ? a / ROWS : a % NB;
    endfunction
    function automatic int row_of(int a);
        return blk ? a % ROWS : a / NB;
    endfunction
    function automatic int phys_of(int a);
        return bank_of(a) * ROWS + row_of(a);
    endfunction
    function automatic logic [DW-1:0] pat(int a, int salt);
        return (DW'(a) * 32'h9E37_79B1) ^ (DW'(salt) << 24);
    endfunction

    task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic drive();
        map_blocked = blk;
        for (int m = 0; m < NM; m++) begin
            m_valid[m]           = p_pend[m];
            m_write[m]           = p_we[m];
            m_addr[m*AW +: AW]   = AW'(p_addr[m]);
            m_wdata[m*DW +: DW]  = p_wd[m];
        end
    endtask

    // One cycle: called at a falling edge, returns at the next falling edge
    task automatic step(string rq);
        logic [NM-1:0] eg;
        logic [NM-1:0] evv;
        logic [DW-1:0] ed [NM];
        drive();
        #2;
        eg = '0;
        for (int b = 0; b < NB; b++) begin
            bit found = 1'b0;
            for (int off = 0; off < NM; off++) begin
                int idx = (exp_ptr[b] + off) % NM;
                if (!found && p_pend[idx] && bank_of(p_addr[idx]) == b) begin
                    found      = 1'b1;
                    eg[idx]    = 1'b1;
                    exp_ptr[b] = (idx + 1) % NM;   // R7
                end
            end
        end
        chk(m_ready === eg, rq, "ready vector", 64'(m_ready), 64'(eg));
        evv = '0;
        for (int m = 0; m < NM; m++) begin
            ed[m] = '0;
            if (eg[m]) begin
                if (p_we[m]) model[phys_of(p_addr[m])] = p_wd[m];
                else begin
                    evv[m] = 1'b1;
                    ed[m]  = model[phys_of(p_addr[m])];
                end
                p_pend[m] = 1'b0;
            end
        end
        @(negedge clk);
        // R8 writes give no response, R9 reads answer one edge later
        chk(m_rvalid === evv, "R9", "rvalid vector", 64'(m_rvalid), 64'(evv));
        for (int m = 0; m < NM; m++)
            if (evv[m])
                chk(m_rdata[m*DW +: DW] === ed[m], "R9", "read data",
                    64'(m_rdata[m*DW +: DW]), 64'(ed[m]));
        drive();
    endtask

    // Held requests (R10) are re-driven unchanged until accepted
    task automatic run_all(string rq, output int steps);
        bit any;
        steps = 0;
        do begin
            any = 1'b0;
            for (int m = 0; m < NM; m++) any |= p_pend[m];
            if (any) begin
                step(rq);
                steps++;
            end
        end while (any && steps < 64);
        if (steps >= 64) chk(1'b0, rq, "batch never drained", 64'(steps), 64'(NM));
    endtask

    task automatic set_req(int m, int a, bit we, logic [DW-1:0] wd);
        p_addr[m] = a; p_we[m] = we; p_wd[m] = wd; p_pend[m] = 1'b1;
    endtask

    initial begin
        int st;
        rst_n = 1'b0;
        blk   = 1'b0;
        for (int m = 0; m < NM; m++) begin
            p_pend[m] = 1'b0; p_we[m] = 1'b0; p_addr[m] = 0; p_wd[m] = '0;
        end
        for (int b = 0; b < NB; b++) exp_ptr[b] = 0;
        drive();
        repeat (3) @(negedge clk);
        // R1
        chk(m_ready === '0, "R1", "ready in reset", 64'(m_ready), 64'(0));
        chk(m_rvalid === '0, "R1", "rvalid in reset", 64'(m_rvalid), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(m_rvalid === '0, "R1", "rvalid after reset", 64'(m_rvalid), 64'(0));
        step("R1");

        // R2 R5 R8: interleaved fill, every master on its own bank
        blk = 1'b0;
        for (int r = 0; r < ROWS; r++) begin
            for (int m = 0; m < NM; m++) set_req(m, r*NB + m, 1'b1, pat(r*NB + m, 1));
            run_all("R2", st);
            chk(st == 1, "R5", "steps distinct banks", 64'(st), 64'(1));
        end

        // R6 R7 R9: all masters collide on one bank
        for (int r = 0; r < ROWS; r++) begin
            for (int m = 0; m < NM; m++) set_req(m, (r + ROWS*m) % WORDS, 1'b0, '0);
            run_all("R6", st);
            chk(st == NM, "R4", "steps full collision", 64'(st), 64'(NM));
        end

        // R7: idle cycles leave pointers alone
        repeat (3) step("R7");

        // R3 R11: blocked readback of interleaved-written data
        blk = 1'b1;
        for (int r = 0; r < ROWS; r++) begin
            for (int m = 0; m < NM; m++) set_req(m, m*ROWS + r, 1'b0, '0);
            run_all("R3", st);
            chk(st == 1, "R5", "steps blocked distinct", 64'(st), 64'(1));
        end

        // R6: blocked writes with mixed conflicts
        for (int r = 0; r < ROWS; r++) begin
            for (int m = 0; m < NM; m++)
                set_req(m, (r*7 + m*3) % WORDS, 1'b1, pat((r*7 + m*3) % WORDS, 2 + m));
            run_all("R6", st);
        end

        // R7: partial requester sets around idle cycles
        set_req(1, 2*ROWS + 5, 1'b0, '0);
        set_req(3, 2*ROWS + 9, 1'b0, '0);
        run_all("R7", st);
        chk(st == 2, "R7", "steps two requesters", 64'(st), 64'(2));
        repeat (2) step("R7");
        set_req(0, 2*ROWS + 1, 1'b0, '0);
        set_req(2, 2*ROWS + 7, 1'b0, '0);
        set_req(3, 2*ROWS + 3, 1'b0, '0);
        run_all("R7", st);

        // R11 R2: back to interleaved, read everything
        blk = 1'b0;
        for (int r = 0; r < ROWS; r++) begin
            for (int m = 0; m < NM; m++) set_req(m, r*NB + m, 1'b0, '0);
            run_all("R11", st);
            chk(st == 1, "R5", "steps interleaved readback", 64'(st), 64'(1));
        end

        // R4 R8: read and write to one address in the same cycle
        for (int r = 0; r < 8; r++) begin
            set_req(0, r*NB, 1'b1, pat(r, 9));
            set_req(1, r*NB, 1'b0, '0);
            set_req(2, r*NB + 2, 1'b1, pat(r, 10));
            set_req(3, r*NB + 2, 1'b0, '0);
            run_all("R4", st);
            chk(st == 2, "R4", "steps read-write pair", 64'(st), 64'(2));
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule